// File: doc/BRIEF.md
# Programmable Event Filter and Conditioner

This block sits in front of a performance counter. Each cycle it takes a vector of raw event strobes together with the attributes of the transaction that raised them (address, initiator ID, privilege level). It reduces them to one increment strobe for the counter behind it. A simple register write port holds the configuration. The configuration chooses which strobes matter, and whether any one of them or all of them together must be present. It also chooses how the selected condition becomes a count: at its level, during its absence, or only on its rising edge. Three optional qualifiers can then veto the count: an address window, a masked initiator ID compare, and a per-privilege inhibit.

The rising-edge option uses a two-state tracker of the selected condition. It has states `TRK_LOW` and `TRK_HIGH`. The tracker takes transition RISE (`TRK_LOW` to `TRK_HIGH`) when the selected condition is true. It takes transition FALL (`TRK_HIGH` to `TRK_LOW`) when the condition is false. Otherwise it holds its state. Reset places it in `TRK_LOW`. An edge is counted only in a cycle that takes RISE. The tracker follows the condition in every mode, so a switch to edge mode starts from the true recent history. The increment output is registered once, so it reports the inputs of the previous cycle.

Top module: `evf_filter_top`

## Requirements
- R1: Reset clears every configuration register and the increment output, and with the cleared configuration no input pattern produces an increment.
- R2: In level mode (control bits [1:0] = 0) with group off (control bit 2 = 0), `incr` is high in the cycle after any strobe that is enabled in the event mask is high. It is low in the cycle after none of them is.
- R3: With group on (control bit 2 = 1), the selected condition is true only when every strobe enabled in the mask is high in the same cycle. An all-zero mask never makes it true.
- R4: In absent mode (control bits [1:0] = 1), an increment is produced for each cycle in which the selected condition of R2/R3 is false.
- R5: In edge mode (control bits [1:0] = 2), an increment is produced only when the selected condition is true and was false in the previous cycle. The stored previous value is false after reset.
- R6: With the address filter on (control bit 3), a count needs `addr_lo <= ev_addr < addr_hi`. With it off, every address passes.
- R7: With the ID filter on (control bit 4), a count needs `ev_id` to equal the ID value in every bit that is set in the ID mask.
- R8: Control bits 5, 6 and 7 inhibit counting at privilege code 0 (user), 1 (supervisor) and 3 (machine) respectively. Privilege code 2 never counts.
- R9: Writes with `cfg_we` high land on the next clock edge: offset 0 is control, 1 the event mask, 2 the address lower bound, 3 the address upper bound, 4 the ID value, 5 the ID mask. Mode value 3 never counts.
- R10: `incr` is the AND of the event condition and all enabled qualifiers, delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| ev_strobe | input | NUM_EVENTS | Raw event strobes |
| ev_addr | input | ADDR_W | Address of the transaction raising the events |
| ev_id | input | ID_W | Initiator ID of that transaction |
| ev_priv | input | 2 | Privilege code of that transaction |
| incr | output | 1 | Registered increment enable for the counter |

## Verification
On every cycle, the assertions check the vetoes. After an empty mask, a present event in absent mode, a held event in edge mode, an address outside the window, the reserved privilege code or the disabled mode, no increment may follow. They also check that a plain level match with no qualifiers always yields one. Only the bench scenarios show the remaining behaviour. These are the exact window boundaries, the masked ID compare, each privilege inhibit bit, the register offsets, and the single increment for a held event followed by re-arming after it falls.

// File: rtl/evf_pkg.sv
`timescale 1ns/1ps
package evf_pkg;
    typedef enum logic [1:0] {
        MODE_LEVEL  = 2'd0,
        MODE_ABSENT = 2'd1,
        MODE_EDGE   = 2'd2,
        MODE_OFF    = 2'd3
    } evf_mode_e;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } evf_priv_e;

    typedef enum logic {
        TRK_LOW  = 1'b0,
        TRK_HIGH = 1'b1
    } evf_trk_e;

    localparam int CFG_AW   = 3;
    localparam int CFG_DW   = 32;
    localparam logic [CFG_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [CFG_AW-1:0] OFS_MASK   = 3'd1;
    localparam logic [CFG_AW-1:0] OFS_LO     = 3'd2;
    localparam logic [CFG_AW-1:0] OFS_HI     = 3'd3;
    localparam logic [CFG_AW-1:0] OFS_IDVAL  = 3'd4;
    localparam logic [CFG_AW-1:0] OFS_IDMASK = 3'd5;
endpackage

// File: rtl/evf_cfg_regs.sv
`timescale 1ns/1ps
module evf_cfg_regs
    import evf_pkg::*;
#(
    parameter int NUM_EVENTS = 8,
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    output evf_mode_e             mode,
    output logic                  group,
    output logic                  addr_en,
    output logic                  id_en,
    output logic [2:0]            inhibit,
    output logic [NUM_EVENTS-1:0] mask,
    output logic [ADDR_W-1:0]     addr_lo,
    output logic [ADDR_W-1:0]     addr_hi,
    output logic [ID_W-1:0]       id_val,
    output logic [ID_W-1:0]       id_mask
);
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_LEVEL;
            group   <= 1'b0;
            addr_en <= 1'b0;
            id_en   <= 1'b0;
            inhibit <= '0;
            mask    <= '0;
            addr_lo <= '0;
            addr_hi <= '0;
            id_val  <= '0;
            id_mask <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                OFS_CTRL: begin
                    mode    <= evf_mode_e'(cfg_wdata[1:0]);
                    group   <= cfg_wdata[2];
                    addr_en <= cfg_wdata[3];
                    id_en   <= cfg_wdata[4];
                    inhibit <= cfg_wdata[7:5];
                end
                OFS_MASK:   mask    <= cfg_wdata[NUM_EVENTS-1:0];
                OFS_LO:     addr_lo <= cfg_wdata[ADDR_W-1:0];
                OFS_HI:     addr_hi <= cfg_wdata[ADDR_W-1:0];
                OFS_IDVAL:  id_val  <= cfg_wdata[ID_W-1:0];
                OFS_IDMASK: id_mask <= cfg_wdata[ID_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/evf_event_select.sv
`timescale 1ns/1ps
module evf_event_select
    import evf_pkg::*;
#(
    parameter int NUM_EVENTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] ev_strobe,
    input  logic [NUM_EVENTS-1:0] mask,
    input  logic                  group,
    input  evf_mode_e             mode,
    output logic                  sel,
    output logic                  cond
);
    evf_trk_e trk_q, trk_d;

    // selected condition: any-of or all-of the masked strobes
    always_comb begin
        if (group) sel = (mask != '0) && ((ev_strobe & mask) == mask);
        else       sel = |(ev_strobe & mask);
    end

    // tracker next state (RISE / FALL / hold)
    always_comb begin
        trk_d = trk_q;
        unique case (trk_q)
            TRK_LOW:  if (sel)  trk_d = TRK_HIGH;
            TRK_HIGH: if (!sel) trk_d = TRK_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= TRK_LOW;
        else        trk_q <= trk_d;
    end

    // output process: condition by counting mode
    always_comb begin
        cond = 1'b0;
        unique case (mode)
            MODE_LEVEL:  cond = sel;
            MODE_ABSENT: cond = !sel;
            MODE_EDGE:   cond = sel && (trk_q == TRK_LOW);
            MODE_OFF:    cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/evf_match.sv
`timescale 1ns/1ps
module evf_match
    import evf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4
) (
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [ID_W-1:0]   ev_id,
    input  logic [1:0]        ev_priv,
    input  logic              addr_en,
    input  logic              id_en,
    input  logic [2:0]        inhibit,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic [ADDR_W-1:0] addr_hi,
    input  logic [ID_W-1:0]   id_val,
    input  logic [ID_W-1:0]   id_mask,
    output logic              pass
);
    logic            addr_ok, id_ok, priv_ok;
    logic [ID_W-1:0] id_bit_ok;

    assign addr_ok = !addr_en || ((ev_addr >= addr_lo) && (ev_addr < addr_hi));

    for (genvar b = 0; b < ID_W; b++) begin : g_id_bit
        assign id_bit_ok[b] = !id_mask[b] || (ev_id[b] == id_val[b]);
    end
    assign id_ok = !id_en || (&id_bit_ok);

    always_comb begin
        priv_ok = 1'b0;
        unique case (evf_priv_e'(ev_priv))
            PRIV_USER:  priv_ok = !inhibit[0];
            PRIV_SUPER: priv_ok = !inhibit[1];
            PRIV_MACH:  priv_ok = !inhibit[2];
            PRIV_RSVD:  priv_ok = 1'b0;
        endcase
    end

    assign pass = addr_ok && id_ok && priv_ok;
endmodule

// File: rtl/evf_filter_top.sv
`timescale 1ns/1ps
module evf_filter_top
    import evf_pkg::*;
#(
    parameter int NUM_EVENTS = 8,
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    input  logic [NUM_EVENTS-1:0] ev_strobe,
    input  logic [ADDR_W-1:0]     ev_addr,
    input  logic [ID_W-1:0]       ev_id,
    input  logic [1:0]            ev_priv,
    output logic                  incr
);
    evf_mode_e             mode;
    logic                  group, addr_en, id_en;
    logic [2:0]            inhibit;
    logic [NUM_EVENTS-1:0] mask;
    logic [ADDR_W-1:0]     addr_lo, addr_hi;
    logic [ID_W-1:0]       id_val, id_mask;
    logic                  sel, cond, pass;

    evf_cfg_regs #(.NUM_EVENTS(NUM_EVENTS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mode(mode), .group(group), .addr_en(addr_en),
        .id_en(id_en), .inhibit(inhibit), .mask(mask), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .id_val(id_val), .id_mask(id_mask)
    );

    evf_event_select #(.NUM_EVENTS(NUM_EVENTS)) u_sel (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .mask(mask),
        .group(group), .mode(mode), .sel(sel), .cond(cond)
    );

    evf_match #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_match (
        .ev_addr(ev_addr), .ev_id(ev_id), .ev_priv(ev_priv), .addr_en(addr_en),
        .id_en(id_en), .inhibit(inhibit), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .id_val(id_val), .id_mask(id_mask), .pass(pass)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) incr <= 1'b0;
        else        incr <= cond && pass;
    end
endmodule

// File: rtl/evf_filter_chk.sv
`timescale 1ns/1ps
module evf_filter_chk #(
    parameter int NUM_EVENTS = 8,
    parameter int ADDR_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  incr,
    input logic [NUM_EVENTS-1:0] ev_strobe,
    input logic [ADDR_W-1:0]     ev_addr,
    input logic [1:0]            ev_priv,
    input logic [1:0]            mode,
    input logic [NUM_EVENTS-1:0] mask,
    input logic                  group,
    input logic                  addr_en,
    input logic                  id_en,
    input logic [2:0]            inhibit,
    input logic [ADDR_W-1:0]     addr_lo,
    input logic [ADDR_W-1:0]     addr_hi,
    input logic                  sel
);
    assert_level_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !group && |(ev_strobe & mask) && !addr_en && !id_en
         && ev_priv == 2'd3 && !inhibit[2]) |=> incr);

    assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && mode != 2'd1) |=> !incr);

    assert_absent_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && sel) |=> !incr);

    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && sel && $past(sel)) |=> !incr);

    assert_addr_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en && (ev_addr < addr_lo || ev_addr >= addr_hi)) |=> !incr);

    assert_priv_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_priv == 2'd2) |=> !incr);

    assert_mode_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> !incr);
endmodule

bind evf_filter_top evf_filter_chk #(.NUM_EVENTS(NUM_EVENTS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .incr(incr), .ev_strobe(ev_strobe),
    .ev_addr(ev_addr), .ev_priv(ev_priv), .mode(mode), .mask(mask),
    .group(group), .addr_en(addr_en), .id_en(id_en), .inhibit(inhibit),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .sel(sel)
);

// File: tb/test_evf_filter_top.sv
`timescale 1ns/1ps
module test_evf_filter_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [7:0]  ev_strobe;
    logic [31:0] ev_addr;
    logic [3:0]  ev_id;
    logic [1:0]  ev_priv;
    logic        incr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    evf_filter_top #(.NUM_EVENTS(8), .ADDR_W(32), .ID_W(4)) i_evf_filter_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ev_strobe(ev_strobe), .ev_addr(ev_addr),
        .ev_id(ev_id), .ev_priv(ev_priv), .incr(incr)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  mask;
        logic [7:0]  ev;
        logic [31:0] addr;
        logic [3:0]  id;
        logic [1:0]  priv;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    // window 0x100..0x1FF, ID value 5 with full mask
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h03, 8'h02, 32'h150, 4'd5, 2'd3, 1'b1, 4'd2},  // R2 any-of hit
        '{8'h00, 8'h03, 8'h04, 32'h150, 4'd5, 2'd3, 1'b0, 4'd2},  // R2 unmasked only
        '{8'h04, 8'h03, 8'h03, 32'h150, 4'd5, 2'd3, 1'b1, 4'd3},  // R3 all present
        '{8'h04, 8'h03, 8'h01, 32'h150, 4'd5, 2'd3, 1'b0, 4'd3},  // R3 one missing
        '{8'h04, 8'h00, 8'hFF, 32'h150, 4'd5, 2'd3, 1'b0, 4'd3},  // R3 empty mask
        '{8'h01, 8'h01, 8'h00, 32'h150, 4'd5, 2'd3, 1'b1, 4'd4},  // R4 absent counts
        '{8'h01, 8'h01, 8'h01, 32'h150, 4'd5, 2'd3, 1'b0, 4'd4},  // R4 present blocks
        '{8'h05, 8'h03, 8'h01, 32'h150, 4'd5, 2'd3, 1'b1, 4'd4},  // R4 group incomplete
        '{8'h02, 8'h01, 8'h01, 32'h150, 4'd5, 2'd3, 1'b1, 4'd5},  // R5 rising edge
        '{8'h08, 8'h01, 8'h01, 32'h100, 4'd5, 2'd3, 1'b1, 4'd6},  // R6 lower bound in
        '{8'h08, 8'h01, 8'h01, 32'h1FF, 4'd5, 2'd3, 1'b1, 4'd6},  // R6 last inside
        '{8'h08, 8'h01, 8'h01, 32'h200, 4'd5, 2'd3, 1'b0, 4'd6},  // R6 upper bound out
        '{8'h08, 8'h01, 8'h01, 32'h0FF, 4'd5, 2'd3, 1'b0, 4'd6},  // R6 below
        '{8'h00, 8'h01, 8'h01, 32'h999, 4'd5, 2'd3, 1'b1, 4'd6},  // R6 filter off
        '{8'h10, 8'h01, 8'h01, 32'h150, 4'd5, 2'd3, 1'b1, 4'd7},  // R7 id match
        '{8'h10, 8'h01, 8'h01, 32'h150, 4'd6, 2'd3, 1'b0, 4'd7},  // R7 id mismatch
        '{8'h80, 8'h01, 8'h01, 32'h150, 4'd5, 2'd3, 1'b0, 4'd8},  // R8 machine inhibited
        '{8'h80, 8'h01, 8'h01, 32'h150, 4'd5, 2'd0, 1'b1, 4'd8},  // R8 user allowed
        '{8'h20, 8'h01, 8'h01, 32'h150, 4'd5, 2'd0, 1'b0, 4'd8},  // R8 user inhibited
        '{8'h40, 8'h01, 8'h01, 32'h150, 4'd5, 2'd1, 1'b0, 4'd8},  // R8 supervisor inhibited
        '{8'h00, 8'h01, 8'h01, 32'h150, 4'd5, 2'd2, 1'b0, 4'd8},  // R8 reserved code
        '{8'h03, 8'h01, 8'h01, 32'h150, 4'd5, 2'd3, 1'b0, 4'd9}   // R9 mode off
    };

    task automatic check(input logic got, input logic exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: incr=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // entered at a negedge, leaves at the next negedge
    task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
        ev_strobe = '0;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic drive_and_check(input logic [7:0] ev, input logic [31:0] a,
                                   input logic [3:0] id, input logic [1:0] pv,
                                   input logic exp, input string req);
        ev_strobe = ev;
        ev_addr   = a;
        ev_id     = id;
        ev_priv   = pv;
        @(negedge clk);
        check(incr, exp, req);
        ev_strobe = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        ev_strobe = '0; ev_addr = 32'h150; ev_id = 4'd5; ev_priv = 2'd3;
        repeat (3) @(negedge clk);
        check(incr, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        // R1: cleared config never counts, even with all strobes high
        drive_and_check(8'hFF, 32'h150, 4'd5, 2'd3, 1'b0, "R1 cleared config");
        drive_and_check(8'hFF, 32'h150, 4'd5, 2'd3, 1'b0, "R1 cleared config again");

        // R9: offsets 2..5 hold window and ID compare values
        write_reg(3'd2, 32'h100);
        write_reg(3'd3, 32'h200);
        write_reg(3'd4, 32'd5);
        write_reg(3'd5, 32'hF);

        for (int i = 0; i < NV; i++) begin
            write_reg(3'd0, {24'd0, VECS[i].ctrl});
            write_reg(3'd1, {24'd0, VECS[i].mask});
            drive_and_check(VECS[i].ev, VECS[i].addr, VECS[i].id, VECS[i].priv,
                            VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R5: held event counts once, re-arms after falling
        write_reg(3'd0, 32'h02);
        write_reg(3'd1, 32'h01);
        ev_addr = 32'h150; ev_id = 4'd5; ev_priv = 2'd3;
        ev_strobe = 8'h01;
        @(negedge clk); check(incr, 1'b1, "R5 first high");
        @(negedge clk); check(incr, 1'b0, "R5 held high 1");
        @(negedge clk); check(incr, 1'b0, "R5 held high 2");
        ev_strobe = 8'h00;
        @(negedge clk); check(incr, 1'b0, "R5 low");
        ev_strobe = 8'h01;
        @(negedge clk); check(incr, 1'b1, "R5 re-armed edge");
        ev_strobe = 8'h00;

        // R10: one-cycle pulse appears exactly one cycle later, then clears
        write_reg(3'd0, 32'h00);
        check(incr, 1'b0, "R10 before pulse");
        ev_strobe = 8'h01;
        @(negedge clk); check(incr, 1'b1, "R10 delayed pulse");
        ev_strobe = 8'h00;
        @(negedge clk); check(incr, 1'b0, "R10 pulse ends");

        // R7: masked-out ID bits are ignored
        write_reg(3'd5, 32'h3);
        write_reg(3'd0, 32'h10);
        drive_and_check(8'h01, 32'h150, 4'd9, 2'd3, 1'b1, "R7 masked bits ignored");
        drive_and_check(8'h01, 32'h150, 4'd6, 2'd3, 1'b0, "R7 masked bit differs");

        // R9: offset 6 is not a register; control stays level mode
        write_reg(3'd0, 32'h00);
        write_reg(3'd6, 32'h03);
        drive_and_check(8'h01, 32'h150, 4'd5, 2'd3, 1'b1, "R9 unmapped offset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule